// File: doc/BRIEF.md
# Prioritized Interrupt Level Arbiter

This block decides when one of two video interrupt sources, horizontal blank and vertical blank, is taken by a processor that masks interrupts with a 3-bit level. Each source has a raise input and a lower input. Behind them sit a line state bit and a pending bit. A pending request is kept until the mask lets it through, so a blocked interrupt is never lost. Lowering a line withdraws its request.

Every cycle the arbiter compares the fixed level of each pending source with its 3-bit mask register. Horizontal blank is considered first. When a source is taken, the block emits a one-cycle accept strobe with a vector select and the accepted level, and it loads that level into the mask. From the next cycle on, only a strictly higher level can be taken. The processor reports other exceptions, which force the mask to 7. It can also load the mask directly, for example when it returns from a handler. Exception stacking and vector fetch stay in the processor.

Top module: `irq_level_arb`

## Requirements
- R1: A raise on source i (index 0 = horizontal blank, index 1 = vertical blank) sets line_o[i] and pend_o[i] in the following cycle, unless lower_i[i] is high in the same cycle.
- R2: A lower on source i clears line_o[i] and pend_o[i] in the following cycle, whatever else is asserted. A source being lowered is not accepted in that cycle.
- R3: Source 0 has level 4 and source 1 has level 6. A pending source is accepted only if its level is strictly greater than mask_o.
- R4: A pending bit stays set until its source is accepted or lowered. A masked request keeps pend_o set. A raise in the same cycle as the acceptance leaves it set.
- R5: At most one source is accepted per cycle. Source 0 wins when both are eligible, and source 1 is taken when source 0 is pending but masked.
- R6: An acceptance decided in cycle k shows in cycle k+1 as take_o=1 for one cycle, with take_vec_o=0 for source 0 or 1 for source 1. In that same cycle mask_o equals the accepted level, so a raise sampled at edge n gives take_o after edge n+1 at the earliest.
- R7: exc_i sets mask_o to 7 in the next cycle, and nothing is accepted in a cycle with exc_i high.
- R8: mask_ld_i loads mask_val_i into mask_o in the next cycle, and nothing is accepted in that cycle. exc_i wins over mask_ld_i.
- R9: After reset, pend_o and line_o are 0, take_o is 0 and mask_o is 7.
- R10: take_lvl_o carries the accepted level (4 or 6) while take_o is high and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raise_i | input | 2 | Per-source raise (bit 0 horizontal, bit 1 vertical) |
| lower_i | input | 2 | Per-source lower |
| exc_i | input | 1 | Other exception taken; mask goes to 7 |
| mask_ld_i | input | 1 | Load mask from mask_val_i |
| mask_val_i | input | 3 | Mask value to load |
| take_o | output | 1 | Accept strobe, one cycle |
| take_vec_o | output | 1 | Accepted source: 0 horizontal, 1 vertical |
| take_lvl_o | output | 3 | Accepted level, 0 when idle |
| mask_o | output | 3 | Current interrupt mask |
| pend_o | output | 2 | Pending bits |
| line_o | output | 2 | Line state bits |

## Verification
The hardest situation to reach is a nested pair. Horizontal blank is taken first, lifting the mask to 4, and vertical blank, still pending, is then taken on the very next cycle. The same case with a blocking mask must instead leave the request latched. To reach it, the bench clears both sources, loads every mask value from 0 to 7, and raises every source combination. It then lets the arbiter run for several cycles while a reference model computed from the requirements tracks each cycle. A long pseudo-random phase then mixes raises, lowers, exceptions and mask loads in the same cycles, which covers the precedence rules.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int MASK_W = 3;
  localparam int NSRC   = 2;
  localparam int VEC_W  = (NSRC > 1) ? $clog2(NSRC) : 1;

  typedef logic [MASK_W-1:0] lvl_t;

  typedef struct packed {
    logic             vld;
    logic [VEC_W-1:0] vec;
    lvl_t             lvl;
  } take_t;

  localparam lvl_t MASK_TOP = {MASK_W{1'b1}};
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raise_i,
  input  logic lower_i,
  input  logic take_i,
  output logic pend_o,
  output logic line_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      line_o <= 1'b0;
    end else begin
      // lower beats raise, raise beats acceptance
      if (lower_i) begin
        pend_o <= 1'b0;
        line_o <= 1'b0;
      end else if (raise_i) begin
        pend_o <= 1'b1;
        line_o <= 1'b1;
      end else if (take_i) begin
        pend_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter logic [NSRC*MASK_W-1:0] LVL_VEC = {3'd6, 3'd4}
) (
  input  logic [NSRC-1:0] elig_i,
  input  lvl_t            mask_i,
  input  logic            busy_i,
  output logic [NSRC-1:0] take_oh_o,
  output take_t           take_o
);
  always_comb begin
    take_oh_o = '0;
    take_o    = '0;
    if (!busy_i) begin
      for (int i = 0; i < NSRC; i++) begin
        if (!take_o.vld && elig_i[i] && (LVL_VEC[i*MASK_W +: MASK_W] > mask_i)) begin
          take_oh_o[i] = 1'b1;
          take_o.vld   = 1'b1;
          take_o.vec   = VEC_W'(i);
          take_o.lvl   = LVL_VEC[i*MASK_W +: MASK_W];
        end
      end
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic exc_i,
  input  logic ld_i,
  input  lvl_t ld_val_i,
  input  logic take_vld_i,
  input  lvl_t take_lvl_i,
  output lvl_t mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mask_o <= MASK_TOP;
    else if (exc_i)      mask_o <= MASK_TOP;
    else if (ld_i)       mask_o <= ld_val_i;
    else if (take_vld_i) mask_o <= take_lvl_i;
  end
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb
  import irq_arb_pkg::*;
#(
  parameter logic [NSRC*MASK_W-1:0] LVL_VEC = {3'd6, 3'd4}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  raise_i,
  input  logic [NSRC-1:0]  lower_i,
  input  logic             exc_i,
  input  logic             mask_ld_i,
  input  logic [MASK_W-1:0] mask_val_i,
  output logic             take_o,
  output logic [VEC_W-1:0] take_vec_o,
  output logic [MASK_W-1:0] take_lvl_o,
  output logic [MASK_W-1:0] mask_o,
  output logic [NSRC-1:0]  pend_o,
  output logic [NSRC-1:0]  line_o
);
  logic [NSRC-1:0] take_oh;
  logic [NSRC-1:0] elig;
  take_t           take_d;
  take_t           take_q;
  logic            busy;

  assign busy = exc_i | mask_ld_i;
  assign elig = pend_o & ~lower_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    irq_src_latch u_latch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raise_i(raise_i[g]),
      .lower_i(lower_i[g]),
      .take_i (take_oh[g]),
      .pend_o (pend_o[g]),
      .line_o (line_o[g])
    );
  end

  irq_pick #(.LVL_VEC(LVL_VEC)) u_pick (
    .elig_i   (elig),
    .mask_i   (mask_o),
    .busy_i   (busy),
    .take_oh_o(take_oh),
    .take_o   (take_d)
  );

  irq_mask_reg u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .exc_i     (exc_i),
    .ld_i      (mask_ld_i),
    .ld_val_i  (mask_val_i),
    .take_vld_i(take_d.vld),
    .take_lvl_i(take_d.lvl),
    .mask_o    (mask_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) take_q <= '0;
    else         take_q <= take_d;
  end

  assign take_o     = take_q.vld;
  assign take_vec_o = take_q.vec;
  assign take_lvl_o = take_q.lvl;
endmodule

// File: rtl/irq_level_arb_chk.sv
module irq_level_arb_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] raise_i,
  input logic [1:0] lower_i,
  input logic       exc_i,
  input logic       mask_ld_i,
  input logic [2:0] mask_val_i,
  input logic       take_o,
  input logic       take_vec_o,
  input logic [2:0] take_lvl_o,
  input logic [2:0] mask_o,
  input logic [1:0] pend_o,
  input logic [1:0] line_o
);
  AST_RAISE_H: assert property (@(posedge clk_i) disable iff (!rst_ni) raise_i[0] && !lower_i[0] |=> pend_o[0] && line_o[0]); // R1
  AST_RAISE_V: assert property (@(posedge clk_i) disable iff (!rst_ni) raise_i[1] && !lower_i[1] |=> pend_o[1] && line_o[1]); // R1
  AST_LOWER_H: assert property (@(posedge clk_i) disable iff (!rst_ni) lower_i[0] |=> !pend_o[0] && !line_o[0] && !(take_o && take_vec_o == 1'b0)); // R2
  AST_LOWER_V: assert property (@(posedge clk_i) disable iff (!rst_ni) lower_i[1] |=> !pend_o[1] && !line_o[1] && !(take_o && take_vec_o == 1'b1)); // R2
  AST_ABOVE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni) take_o |-> take_lvl_o > $past(mask_o)); // R3
  AST_VEC_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni) take_o |-> (take_vec_o ? take_lvl_o == 3'd6 : take_lvl_o == 3'd4)); // R3
  AST_MASKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) pend_o[0] && !lower_i[0] && mask_o >= 3'd4 |=> pend_o[0]); // R4
  AST_NO_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni) take_o |=> !(take_o && take_vec_o == $past(take_vec_o))); // R6
  AST_MASK_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni) take_o |-> mask_o == take_lvl_o); // R6
  AST_EXC_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni) exc_i |=> mask_o == 3'd7 && !take_o); // R7
  AST_LD_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni) mask_ld_i && !exc_i |=> mask_o == $past(mask_val_i) && !take_o); // R8
  AST_IDLE_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni) !take_o |-> take_lvl_o == 3'd0); // R10
endmodule

bind irq_level_arb irq_level_arb_chk chk_i (.*);

// File: tb/irq_level_arb_tb.sv
module irq_level_arb_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] raise_i = '0;
  logic [1:0] lower_i = '0;
  logic       exc_i = 1'b0;
  logic       mask_ld_i = 1'b0;
  logic [2:0] mask_val_i = '0;
  logic       take_o;
  logic       take_vec_o;
  logic [2:0] take_lvl_o;
  logic [2:0] mask_o;
  logic [1:0] pend_o;
  logic [1:0] line_o;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  irq_level_arb dut_i (.*);

  // reference model from requirements
  logic [1:0] m_pend, m_line;
  logic [2:0] m_mask, m_lvl;
  logic       m_take, m_vec;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pend = 0; m_line = 0; m_mask = 7; m_take = 0; m_vec = 0; m_lvl = 0;
    end else begin
      logic busy, th, tv;
      busy = exc_i | mask_ld_i;
      th = !busy && m_pend[0] && !lower_i[0] && (3'd4 > m_mask);
      tv = !busy && !th && m_pend[1] && !lower_i[1] && (3'd6 > m_mask);
      for (int i = 0; i < 2; i++) begin
        logic t;
        t = (i == 0) ? th : tv;
        if (lower_i[i]) begin m_pend[i] = 0; m_line[i] = 0; end
        else if (raise_i[i]) begin m_pend[i] = 1; m_line[i] = 1; end
        else if (t) m_pend[i] = 0;
      end
      if (exc_i) m_mask = 7;
      else if (mask_ld_i) m_mask = mask_val_i;
      else if (th) m_mask = 4;
      else if (tv) m_mask = 6;
      m_take = th | tv;
      m_vec = tv;
      m_lvl = th ? 3'd4 : (tv ? 3'd6 : 3'd0);
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  bit cmp_en = 0;
  always @(negedge clk_i) begin
    cyc++;
    if (cmp_en && rst_ni) begin
      chk("R5 take_o", {7'd0, take_o}, {7'd0, m_take});
      if (m_take) chk("R6 take_vec_o", {7'd0, take_vec_o}, {7'd0, m_vec});
      chk("R3 R10 take_lvl_o", {5'd0, take_lvl_o}, {5'd0, m_lvl});
      chk("R7 R8 mask_o", {5'd0, mask_o}, {5'd0, m_mask});
      chk("R4 pend_o", {6'd0, pend_o}, {6'd0, m_pend});
      chk("R1 line_o", {6'd0, line_o}, {6'd0, m_line});
    end
  end

  task automatic idle();
    raise_i = 0; lower_i = 0; exc_i = 0; mask_ld_i = 0; mask_val_i = 0;
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R9 reset state
    chk("R9 mask_o", {5'd0, mask_o}, 8'd7);
    chk("R9 pend_o", {6'd0, pend_o}, 8'd0);
    chk("R9 line_o", {6'd0, line_o}, 8'd0);
    chk("R9 take_o", {7'd0, take_o}, 8'd0);
    cmp_en = 1;

    // sweep: every mask value and raise pattern
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 4; p++) begin
        idle(); lower_i = 2'b11; mask_ld_i = 1; mask_val_i = 3'(m);
        step();
        idle(); raise_i = 2'(p);
        step();
        idle();
        repeat (4) step();
      end
    end

    // R6 timing and nesting: mask 0, both raised
    idle(); lower_i = 2'b11; mask_ld_i = 1; mask_val_i = 0; step();
    idle(); raise_i = 2'b11; step();
    idle(); chk("R6 no take one edge after raise", {7'd0, take_o}, 8'd0); step();
    chk("R5 hblank first", {6'd0, take_o, take_vec_o}, 8'b10);
    chk("R6 mask follows", {5'd0, mask_o}, 8'd4);
    step();
    chk("R5 vblank nested", {6'd0, take_o, take_vec_o}, 8'b11);
    chk("R10 lvl 6", {5'd0, take_lvl_o}, 8'd6);
    step();
    chk("R6 pulse ends", {7'd0, take_o}, 8'd0);

    // R5 hblank masked, vblank passes at mask 5
    idle(); lower_i = 2'b11; mask_ld_i = 1; mask_val_i = 5; step();
    idle(); raise_i = 2'b11; step();
    idle(); step();
    chk("R5 vblank over masked hblank", {6'd0, take_o, take_vec_o}, 8'b11);
    chk("R4 hblank stays pending", {6'd0, pend_o}, 8'b01);
    step();

    // R2 lower in the cycle it would be taken
    idle(); mask_ld_i = 1; mask_val_i = 0; lower_i = 2'b10; step();
    // hblank pending from above becomes eligible now; lower it
    idle(); lower_i = 2'b01; step();
    idle();
    chk("R2 lowered not taken", {7'd0, take_o}, 8'd0);
    chk("R2 pend cleared", {6'd0, pend_o}, 8'd0);
    chk("R2 line cleared", {6'd0, line_o}, 8'd0);

    // R8 load blocks acceptance; R7 exception wins over load
    idle(); mask_ld_i = 1; mask_val_i = 7; step();
    idle(); raise_i = 2'b01; step();
    idle(); mask_ld_i = 1; mask_val_i = 0; step();
    idle();
    chk("R8 no take during load", {7'd0, take_o}, 8'd0);
    chk("R8 mask loaded", {5'd0, mask_o}, 8'd0);
    step();
    chk("R8 take after load", {6'd0, take_o, take_vec_o}, 8'b10);
    idle(); exc_i = 1; mask_ld_i = 1; mask_val_i = 2; step();
    idle();
    chk("R7 exc beats load", {5'd0, mask_o}, 8'd7);

    // R4 raise with acceptance keeps pending
    idle(); mask_ld_i = 1; mask_val_i = 0; step();
    idle(); raise_i = 2'b01; step();
    idle(); raise_i = 2'b01; step();
    idle();
    chk("R4 raise on accept repends", {6'd0, pend_o}, 8'b01);
    chk("R6 accepted", {7'd0, take_o}, 8'd1);

    // pseudo-random mix
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int k = 0; k < 3000; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        raise_i    = lfsr[1:0] & {lfsr[9], lfsr[8]};
        lower_i    = lfsr[3:2] & {lfsr[11], lfsr[10]} & {lfsr[12], lfsr[12]};
        exc_i      = (lfsr[7:4] == 4'h0);
        mask_ld_i  = (lfsr[7:5] == 3'h7);
        mask_val_i = lfsr[15:13];
        step();
      end
    end
    idle(); step();

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule